// File: doc/BRIEF.md
# Serial In-System Programming Slave Controller

This block lets an external programmer load and inspect the on-chip code store over a four-wire serial link while the chip is held in its programming state. The programmer drives a serial clock and a data-in line; the block answers on a data-out line. Every instruction is four bytes, except the page forms, which carry an opcode, a page number and then 256 data bytes in a row. A behavioural byte array stands in for the code store. Erasing and single-byte writes are self-timed and hold a busy flag high while they run.

The serial clock and data are brought into the system clock domain through a flip-flop chain, and rising edges of the synchronised clock do all the work. Input data is taken at each rising edge, most significant bit first. The output line changes a few system clocks after each rising edge, so the programmer samples each response bit at the next rising edge. A freshly entered programming session first ignores the serial clock for a settling window. After that, every instruction except the enable instruction is dropped until the enable instruction has been received. Programming cells only clear bits, so changing a byte to a value with more ones needs an erase first.

Top module: `spiprog_ctrl`

## Requirements
- R1: While `rst_n` is low the outputs `miso`, `busy`, `mem_we` and `erase_stb` are 0. One clock after `prog_mode` is low, `miso` is 0.
- R2: Rising edges of `sck` in the first GUARD_CYC (64) clocks after `prog_mode` goes high are ignored and do not shift any bit into the instruction.
- R3: An instruction is four bytes, each sent most significant bit first and taken at rising `sck`. Response bits are sent most significant bit first. Each bit is valid from shortly after a rising edge until the next rising edge.
- R4: After `prog_mode` rises, every instruction except enable (0xAC 0x53 xx xx) is ignored until enable has been received. An ignored write leaves `busy` at 0.
- R5: Erase (0xAC 0x80 xx xx) pulses `erase_stb` for one clock at the end of the fourth byte. It then holds `busy` high while 2**ADDR_W locations are set to 0xFF, one per clock.
- R6: A byte or page read issued while erase is running returns 0x00.
- R7: Byte read (0x20 hi lo xx) returns the stored byte at address {hi,lo} (low ADDR_W bits) during the fourth byte.
- R8: Byte write (0x40 hi lo d) holds `busy` for WRITE_CYC clocks. It then stores the old value AND d and pulses `mem_we` once. Commands that would start an erase or a write while `busy` is high are dropped.
- R9: While a byte write is running, a read of the address being written returns the complement of bit 7 of the written data in bit 7, with bits 6..0 at 0.
- R10: Page write (0x50 p) is followed by 256 data bytes for offsets 0..255 of page p. Each byte is ANDed into the store at the end of its byte, unless `busy` is high.
- R11: Page read (0x30 p) returns the bytes at offsets 0..255 of page p during the 256 bytes that follow. The next byte after them is decoded as an opcode.
- R12: Taking `prog_mode` low drops any partly received instruction and clears the enabled state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High while the chip is held in programming state |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial response data |
| busy | output | 1 | Erase or byte write in progress |
| mem_we | output | 1 | One-clock pulse on each data write into the store |
| erase_stb | output | 1 | One-clock pulse when an erase starts |

## Verification
The assertions assume that `sck` has a period of at least 16 system clocks, that `mosi` changes only while `sck` is low, and that `prog_mode` changes only away from clock edges. The bench drives each serial half-period as 10 system clocks. It sets `mosi` one half-period before each rising edge and samples `miso` just before the edge. It changes `prog_mode` and `rst_n` only on falling clock edges. Every writing command except the deliberate polling and erase-overlap cases is sent only after the bench has seen `busy` return low.

// File: rtl/spiprog_pkg.sv
package spiprog_pkg;
  localparam logic [7:0] OP_GATE    = 8'hAC;
  localparam logic [7:0] SUB_ENABLE = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_RD_BYTE = 8'h20;
  localparam logic [7:0] OP_WR_BYTE = 8'h40;
  localparam logic [7:0] OP_RD_PAGE = 8'h30;
  localparam logic [7:0] OP_WR_PAGE = 8'h50;

  typedef enum logic [2:0] {
    PH_CMD, PH_ARG1, PH_ARG2, PH_ARG3, PH_PAGE
  } phase_t;

  typedef enum logic [1:0] {
    MS_IDLE, MS_ERASE, MS_WRITE
  } mstate_t;
endpackage

// File: rtl/spiprog_sync.sv
module spiprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_pipe, sck_pipe_d;
  logic [STAGES-1:0] mosi_pipe, mosi_pipe_d;
  logic              sck_prev;

  always_comb begin
    sck_pipe_d  = {sck_pipe[STAGES-2:0], sck_i};
    mosi_pipe_d = {mosi_pipe[STAGES-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_pipe  <= sck_pipe_d;
      mosi_pipe <= mosi_pipe_d;
      sck_prev  <= sck_pipe[STAGES-1];
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign mosi_s   = mosi_pipe[STAGES-1];
endmodule

// File: rtl/spiprog_guard.sv
module spiprog_guard #(
  parameter int GUARD_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  output logic ready
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GUARD_CYC);

  logic [CW-1:0] cnt, cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (!prog_mode)        cnt_d = '0;
    else if (cnt != LIMIT) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/spiprog_mem.sv
module spiprog_mem
  import spiprog_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WRITE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pg_we,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [7:0]        pg_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              mem_we,
  output logic              erase_stb
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int TW    = $clog2(WRITE_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [TW-1:0]     LAST_TICK = TW'(WRITE_CYC - 1);

  logic [7:0] store [DEPTH];

  mstate_t           st, st_d;
  logic [ADDR_W-1:0] ptr, ptr_d;
  logic [TW-1:0]     tmr, tmr_d;
  logic [ADDR_W-1:0] lat_addr, lat_addr_d;
  logic [7:0]        lat_data, lat_data_d;

  logic              commit;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        arr_din;

  // sequencer next state
  always_comb begin
    st_d       = st;
    ptr_d      = ptr;
    tmr_d      = tmr;
    lat_addr_d = lat_addr;
    lat_data_d = lat_data;
    commit     = 1'b0;
    erase_stb  = 1'b0;
    case (st)
      MS_IDLE: begin
        if (erase_req) begin
          st_d      = MS_ERASE;
          ptr_d     = '0;
          erase_stb = 1'b1;
        end else if (wr_req) begin
          st_d       = MS_WRITE;
          tmr_d      = '0;
          lat_addr_d = wr_addr;
          lat_data_d = wr_data;
        end
      end
      MS_ERASE: begin
        ptr_d = ptr + 1'b1;
        if (ptr == LAST_ADDR) st_d = MS_IDLE;
      end
      MS_WRITE: begin
        tmr_d = tmr + 1'b1;
        if (tmr == LAST_TICK) begin
          st_d   = MS_IDLE;
          commit = 1'b1;
        end
      end
      default: st_d = MS_IDLE;
    endcase
  end

  // single array write port
  always_comb begin
    arr_we   = 1'b0;
    arr_addr = pg_addr;
    arr_din  = store[pg_addr] & pg_data;
    if (st == MS_ERASE) begin
      arr_we   = 1'b1;
      arr_addr = ptr;
      arr_din  = 8'hFF;
    end else if (commit) begin
      arr_we   = 1'b1;
      arr_addr = lat_addr;
      arr_din  = store[lat_addr] & lat_data;
    end else if (st == MS_IDLE && pg_we) begin
      arr_we   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) store[arr_addr] <= arr_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= MS_IDLE;
      ptr      <= '0;
      tmr      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      st       <= st_d;
      ptr      <= ptr_d;
      tmr      <= tmr_d;
      lat_addr <= lat_addr_d;
      lat_data <= lat_data_d;
    end
  end

  // read view: erase masks, write in flight polls
  always_comb begin
    if (st == MS_ERASE)
      rd_data = 8'h00;
    else if (st == MS_WRITE && rd_addr == lat_addr)
      rd_data = {~lat_data[7], 7'b0};
    else
      rd_data = store[rd_addr];
  end

  assign busy   = (st != MS_IDLE);
  assign mem_we = commit | (st == MS_IDLE && pg_we);

  // R5
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> busy);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, erase_stb}));
endmodule

// File: rtl/spiprog_ctrl.sv
module spiprog_ctrl
  import spiprog_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int WRITE_CYC   = 1000,
  parameter int GUARD_CYC   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy,
  output logic mem_we,
  output logic erase_stb
);
  localparam int PAGE_W = ADDR_W - 8;

  logic sck_rise, mosi_s, guard_ok;

  phase_t      phase, phase_d;
  logic [2:0]  bit_cnt, bit_cnt_d;
  logic [6:0]  in_sr, in_sr_d;
  logic [7:0]  op, op_d;
  logic [7:0]  arg1, arg1_d;
  logic [7:0]  arg2, arg2_d;
  logic [7:0]  page_idx, page_idx_d;
  logic        enabled, enabled_d;
  logic [7:0]  out_sr, out_sr_d;

  logic [7:0]        shift_byte;
  logic              step, byte_end;
  logic              erase_req, wr_req, pg_we;
  logic [ADDR_W-1:0] rd_addr, wr_addr, pg_addr;
  logic [7:0]        rd_data;

  spiprog_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi),
    .sck_rise(sck_rise), .mosi_s(mosi_s)
  );

  spiprog_guard #(.GUARD_CYC(GUARD_CYC)) guard_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .ready(guard_ok)
  );

  spiprog_mem #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .erase_req(erase_req), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(shift_byte),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(shift_byte),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .mem_we(mem_we), .erase_stb(erase_stb)
  );

  assign shift_byte = {in_sr, mosi_s};
  assign step       = sck_rise & guard_ok & prog_mode;
  assign byte_end   = step & (bit_cnt == 3'd7);
  assign wr_addr    = {arg1[PAGE_W-1:0], arg2};
  assign pg_addr    = {arg1[PAGE_W-1:0], page_idx};

  // address of the byte to be returned next
  always_comb begin
    case (phase)
      PH_ARG1: rd_addr = {shift_byte[PAGE_W-1:0], 8'h00};
      PH_ARG2: rd_addr = {arg1[PAGE_W-1:0], shift_byte};
      PH_PAGE: rd_addr = {arg1[PAGE_W-1:0], page_idx + 8'd1};
      default: rd_addr = {arg1[PAGE_W-1:0], arg2};
    endcase
  end

  // instruction decoder next state
  always_comb begin
    phase_d    = phase;
    bit_cnt_d  = bit_cnt;
    in_sr_d    = in_sr;
    op_d       = op;
    arg1_d     = arg1;
    arg2_d     = arg2;
    page_idx_d = page_idx;
    enabled_d  = enabled;
    out_sr_d   = out_sr;
    erase_req  = 1'b0;
    wr_req     = 1'b0;
    pg_we      = 1'b0;
    if (!prog_mode) begin
      phase_d   = PH_CMD;
      bit_cnt_d = '0;
      in_sr_d   = '0;
      enabled_d = 1'b0;
      out_sr_d  = '0;
    end else if (step) begin
      bit_cnt_d = bit_cnt + 1'b1;
      in_sr_d   = shift_byte[6:0];
      out_sr_d  = {out_sr[6:0], 1'b0};
      if (byte_end) begin
        out_sr_d = '0;
        case (phase)
          PH_CMD: begin
            op_d    = shift_byte;
            phase_d = PH_ARG1;
          end
          PH_ARG1: begin
            arg1_d = shift_byte;
            if (op == OP_GATE && shift_byte == SUB_ENABLE) enabled_d = 1'b1;
            if (enabled && (op == OP_RD_PAGE || op == OP_WR_PAGE)) begin
              phase_d    = PH_PAGE;
              page_idx_d = '0;
              if (op == OP_RD_PAGE) out_sr_d = rd_data;
            end else begin
              phase_d = PH_ARG2;
            end
          end
          PH_ARG2: begin
            arg2_d  = shift_byte;
            phase_d = PH_ARG3;
            if (enabled && op == OP_RD_BYTE) out_sr_d = rd_data;
          end
          PH_ARG3: begin
            phase_d = PH_CMD;
            if (enabled && op == OP_WR_BYTE) wr_req = 1'b1;
            if (enabled && op == OP_GATE && arg1 == SUB_ERASE) erase_req = 1'b1;
          end
          PH_PAGE: begin
            page_idx_d = page_idx + 1'b1;
            if (op == OP_WR_PAGE) pg_we = 1'b1;
            if (page_idx == 8'hFF)       phase_d  = PH_CMD;
            else if (op == OP_RD_PAGE)   out_sr_d = rd_data;
          end
          default: phase_d = PH_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      in_sr    <= '0;
      op       <= '0;
      arg1     <= '0;
      arg2     <= '0;
      page_idx <= '0;
      enabled  <= 1'b0;
      out_sr   <= '0;
    end else begin
      phase    <= phase_d;
      bit_cnt  <= bit_cnt_d;
      in_sr    <= in_sr_d;
      op       <= op_d;
      arg1     <= arg1_d;
      arg2     <= arg2_d;
      page_idx <= page_idx_d;
      enabled  <= enabled_d;
      out_sr   <= out_sr_d;
    end
  end

  assign miso = out_sr[7];

  // R1
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !miso);

  // R4
  gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enabled));

  // R2
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_ok && prog_mode && $past(prog_mode)) |=> $stable(bit_cnt));
endmodule

// File: tb/spiprog_ctrl_tb_top.sv
module spiprog_ctrl_tb_top;
  localparam int HALF  = 10;
  localparam int GUARD = 64;

  logic clk, rst_n, prog_mode, sck, mosi;
  logic miso, busy, mem_we, erase_stb;

  int checks, failures, we_cnt;
  bit done;

  spiprog_ctrl #(.ADDR_W(11), .WRITE_CYC(1000), .GUARD_CYC(GUARD)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .mem_we(mem_we), .erase_stb(erase_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && mem_we) we_cnt <= we_cnt + 1;

  // {b0,b1,b2,b3,expected 4th-byte reply,check,wait idle}
  localparam logic [41:0] VEC [10] = '{
    {8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1},
    {8'h20, 8'h00, 8'h05, 8'h00, 8'hFF, 1'b1, 1'b0},
    {8'h40, 8'h00, 8'h05, 8'hA5, 8'h00, 1'b0, 1'b1},
    {8'h20, 8'h00, 8'h05, 8'h00, 8'hA5, 1'b1, 1'b0},
    {8'h40, 8'h01, 8'h23, 8'h3C, 8'h00, 1'b0, 1'b1},
    {8'h20, 8'h01, 8'h23, 8'h00, 8'h3C, 1'b1, 1'b0},
    {8'h20, 8'h00, 8'h05, 8'h00, 8'hA5, 1'b1, 1'b0},
    {8'h40, 8'h00, 8'h05, 8'h5A, 8'h00, 1'b0, 1'b1},
    {8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, output logic [7:0] r3);
    logic [7:0] dummy;
    spi_byte(b0, dummy);
    spi_byte(b1, dummy);
    spi_byte(b2, dummy);
    spi_byte(b3, r3);
  endtask

  task automatic wait_idle();
    tick(2);
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic reenter();
    prog_mode = 1'b0;
    tick(4);
    prog_mode = 1'b1;
    tick(GUARD + 10);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    int we_before;
    checks = 0; failures = 0; we_cnt = 0; done = 0;
    rst_n = 1'b0; prog_mode = 1'b0; sck = 1'b0; mosi = 1'b0;
    tick(5);
    // R1 reset state
    check({4'b0, miso, busy, mem_we, erase_stb}, 8'h00, "R1 outputs in reset");
    rst_n = 1'b1;
    tick(3);
    check({4'b0, miso, busy, mem_we, erase_stb}, 8'h00, "R1 outputs after reset");
    prog_mode = 1'b1;
    tick(GUARD + 10);

    // table walk: R3 R5 R7 R8
    for (int k = 0; k < 10; k++) begin
      frame(VEC[k][41:34], VEC[k][33:26], VEC[k][25:18], VEC[k][17:10], r);
      if (VEC[k][1]) check(r, VEC[k][9:2], "R3/R7/R8 table read");
      if (VEC[k][0]) wait_idle();
    end

    // R1 miso low with prog_mode low; R2 stray edges in guard window
    prog_mode = 1'b0;
    tick(3);
    check({7'b0, miso}, 8'h00, "R1 miso with prog_mode low");
    prog_mode = 1'b1;
    mosi = 1'b1;
    for (int p = 0; p < 2; p++) begin
      tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    mosi = 1'b0;
    tick(GUARD);
    // R4 write before enable is ignored
    frame(8'h40, 8'h00, 8'h07, 8'h00, r);
    tick(2);
    check({7'b0, busy}, 8'h00, "R4 write before enable leaves busy low");
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
    frame(8'h20, 8'h00, 8'h07, 8'h00, r);
    check(r, 8'hFF, "R2/R4 read after guard and enable");
    frame(8'h20, 8'h01, 8'h23, 8'h00, r);
    check(r, 8'h3C, "R2 frame alignment");

    // R5 R6 erase and reads during it
    frame(8'hAC, 8'h80, 8'h00, 8'h00, r);
    frame(8'h20, 8'h01, 8'h23, 8'h00, r);
    check(r, 8'h00, "R6 read during erase");
    check({7'b0, busy}, 8'h01, "R5 busy during erase");
    wait_idle();
    frame(8'h20, 8'h01, 8'h23, 8'h00, r);
    check(r, 8'hFF, "R5 erased value");

    // R8 R9 write with polling
    we_before = we_cnt;
    frame(8'h40, 8'h00, 8'h09, 8'h7F, r);
    tick(2);
    check({7'b0, busy}, 8'h01, "R8 busy during write");
    frame(8'h20, 8'h00, 8'h09, 8'h00, r);
    check(r, 8'h80, "R9 data polling");
    wait_idle();
    check(8'(we_cnt - we_before), 8'h01, "R8 single mem_we pulse");
    frame(8'h20, 8'h00, 8'h09, 8'h00, r);
    check(r, 8'h7F, "R8 written value");

    // R10 page write, R11 page read
    spi_byte(8'h50, r);
    spi_byte(8'h03, r);
    for (int i = 0; i < 256; i++) spi_byte(8'(i) ^ 8'h5A, r);
    spi_byte(8'h30, r);
    spi_byte(8'h03, r);
    for (int i = 0; i < 256; i++) begin
      spi_byte(8'h00, r);
      check(r, 8'(i) ^ 8'h5A, "R10/R11 page data");
    end
    frame(8'h20, 8'h03, 8'h10, 8'h00, r);
    check(r, 8'h4A, "R11 decode after page");

    // R12 partial instruction abandoned
    spi_byte(8'h40, r);
    spi_byte(8'h03, r);
    reenter();
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
    frame(8'h20, 8'h03, 8'h11, 8'h00, r);
    check(r, 8'h4B, "R12 partial frame dropped");

    done = 1;
    finish_run();
  end
endmodule